// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block holds a hart's current privilege level and the three machine status fields that stack around a trap: the interrupt enable, its saved copy, and the saved privilege. It reacts to two one-cycle strobes. A trap strobe carries a cause word and the faulting PC. The block records both, stacks the privilege and enable state, enters machine mode and produces the fetch redirect address. A return strobe unstacks that state and produces the saved PC as the redirect address.

The redirect address is combinational during the strobe cycle. For a trap it comes from a vector register that the surrounding core supplies. Bit 0 of that register selects vectored dispatch, and vectored dispatch applies only when the top bit of the cause (the interrupt flag) is set. A narrow status load port lets the core place values into the stacked fields. That port has the lowest priority.

Top module: `trap_seq`

## Requirements
- R1: After reset, privilege is machine (encoding 3), the enable and saved-enable bits are 0, the saved privilege is user (encoding 0), and the cause and exception PC registers are 0.
- R2: On a trap strobe, the saved privilege takes the privilege held before the strobe, and the privilege becomes machine (3) on the next cycle.
- R3: On a trap strobe, the saved-enable bit becomes 1 if the enable bit was 1 and otherwise keeps its value. The enable bit becomes 0.
- R4: On a trap strobe, the cause register loads the supplied cause and the exception PC register loads the supplied PC, unaltered.
- R5: During a trap strobe, the redirect address is the vector register with bit 0 forced to 0 whenever vector bit 0 is 0 or the cause top bit (bit XLEN-1) is 0.
- R6: During a trap strobe with vector bit 0 set and cause bit XLEN-1 set, the redirect address is the base from R5 plus 4 times the cause with its top bit removed, modulo 2^XLEN.
- R7: On a return strobe, the privilege loads the saved privilege and the saved-enable bit becomes 0. The enable bit becomes 1 if the saved-enable bit was 1 and otherwise keeps its value. The saved privilege is unchanged.
- R8: The redirect-valid output is high exactly in cycles where a trap or return strobe is high. During a return-only strobe, the redirect address equals the exception PC register as it stood before that strobe.
- R9: When the trap and return strobes are high together, the block behaves exactly as for a trap alone, both in its redirect output and in its state update.
- R10: A status load with no strobe writes the enable and saved-enable bits. It writes the saved privilege as 0 for a written value of 0 and as 3 for any other value. A status load in the same cycle as a trap or return strobe is ignored.
- R11: In a cycle with no strobe and no status load, the privilege, status fields, cause and exception PC all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | One-cycle trap entry strobe |
| trapCause | input | XLEN | Cause word; top bit flags an interrupt |
| trapPc | input | XLEN | PC of the trapping instruction |
| retValid | input | 1 | One-cycle return-from-trap strobe |
| vecBase | input | XLEN | Trap vector register; bit 0 selects vectored dispatch |
| statusWrEn | input | 1 | Status load strobe |
| statusWrMie | input | 1 | Enable bit value to load |
| statusWrMpie | input | 1 | Saved-enable bit value to load |
| statusWrMpp | input | 2 | Saved privilege value to load (legalized) |
| privLevel | output | 2 | Current privilege: 0 user, 3 machine |
| statusMie | output | 1 | Interrupt enable bit |
| statusMpie | output | 1 | Saved interrupt enable bit |
| statusMpp | output | 2 | Saved privilege |
| causeReg | output | XLEN | Captured cause |
| epcReg | output | XLEN | Captured exception PC |
| redirectValid | output | 1 | Redirect address valid this cycle |
| redirectPc | output | XLEN | Redirect address |

## Verification
The bench builds the block with XLEN set to 8. At that width, every pairing of cause word and vector register can be driven through a trap. This covers direct and vectored dispatch, the modulo wrap of the vectored offset, and a vector bit 0 set together with a non-interrupt cause. A second sweep covers each combination of privilege, enable, saved-enable and saved privilege against trap-only, return-only and both-strobe cycles, and against a status load that collides with a strobe, so the set-only stacking and the priority order are each reached from every state.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  typedef enum logic [1:0] {
    PRIV_USER    = 2'b00,
    PRIV_MACHINE = 2'b11
  } privT;

  typedef struct packed {
    logic doTrap;
    logic doRet;
    logic doLoad;
    logic useVector;
    logic redirect;
  } seqCtrlT;

endpackage

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
(
  input  logic    trapValid,
  input  logic    retValid,
  input  logic    statusWrEn,
  input  logic    vecModeBit,
  input  logic    causeIrqBit,
  output seqCtrlT ctrl
);

  always_comb begin
    ctrl           = '0;
    ctrl.doTrap    = trapValid;
    ctrl.doRet     = retValid && !trapValid;
    ctrl.doLoad    = statusWrEn && !trapValid && !retValid;
    ctrl.useVector = trapValid && vecModeBit && causeIrqBit;
    ctrl.redirect  = trapValid || retValid;
  end

endmodule

// File: rtl/trap_seq_datapath.sv
module trap_seq_datapath
  import trap_seq_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtrlT          ctrl,
  input  logic [XLEN-1:0]  trapCause,
  input  logic [XLEN-1:0]  trapPc,
  input  logic [XLEN-1:1]  vecUpper,
  input  logic             wrMie,
  input  logic             wrMpie,
  input  logic [1:0]       wrMpp,
  output logic [1:0]       privOut,
  output logic             mieOut,
  output logic             mpieOut,
  output logic [1:0]       mppOut,
  output logic [XLEN-1:0]  causeOut,
  output logic [XLEN-1:0]  epcOut,
  output logic [XLEN-1:0]  redirectPc
);

  localparam int CODE_MSB = XLEN - 1 - STRIDE_LOG2;

  privT            privQ, mppQ;
  logic            mieQ, mpieQ;
  logic [XLEN-1:0] causeQ, epcQ;

  logic [XLEN-1:0] vecAligned;
  logic [XLEN-1:0] vecOffset;
  logic [XLEN-1:0] trapTarget;
  privT            mppLegal;

  assign vecAligned = {vecUpper, 1'b0};
  assign vecOffset  = {trapCause[CODE_MSB:0], {STRIDE_LOG2{1'b0}}};
  assign trapTarget = ctrl.useVector ? (vecAligned + vecOffset) : vecAligned;
  assign mppLegal   = (wrMpp == 2'b00) ? PRIV_USER : PRIV_MACHINE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      privQ  <= PRIV_MACHINE;
      mppQ   <= PRIV_USER;
      mieQ   <= 1'b0;
      mpieQ  <= 1'b0;
      causeQ <= '0;
      epcQ   <= '0;
    end else if (ctrl.doTrap) begin
      mppQ   <= privQ;
      privQ  <= PRIV_MACHINE;
      if (mieQ) mpieQ <= 1'b1;
      mieQ   <= 1'b0;
      causeQ <= trapCause;
      epcQ   <= trapPc;
    end else if (ctrl.doRet) begin
      privQ  <= mppQ;
      if (mpieQ) mieQ <= 1'b1;
      mpieQ  <= 1'b0;
    end else if (ctrl.doLoad) begin
      mieQ   <= wrMie;
      mpieQ  <= wrMpie;
      mppQ   <= mppLegal;
    end
  end

  assign redirectPc = ctrl.doTrap ? trapTarget : epcQ;
  assign privOut    = privQ;
  assign mppOut     = mppQ;
  assign mieOut     = mieQ;
  assign mpieOut    = mpieQ;
  assign causeOut   = causeQ;
  assign epcOut     = epcQ;

endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapValid,
  input  logic [XLEN-1:0] trapCause,
  input  logic [XLEN-1:0] trapPc,
  input  logic            retValid,
  input  logic [XLEN-1:0] vecBase,
  input  logic            statusWrEn,
  input  logic            statusWrMie,
  input  logic            statusWrMpie,
  input  logic [1:0]      statusWrMpp,
  output logic [1:0]      privLevel,
  output logic            statusMie,
  output logic            statusMpie,
  output logic [1:0]      statusMpp,
  output logic [XLEN-1:0] causeReg,
  output logic [XLEN-1:0] epcReg,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectPc
);

  seqCtrlT ctrl;

  trap_seq_ctrl u_ctrl (
    .trapValid  (trapValid),
    .retValid   (retValid),
    .statusWrEn (statusWrEn),
    .vecModeBit (vecBase[0]),
    .causeIrqBit(trapCause[XLEN-1]),
    .ctrl       (ctrl)
  );

  trap_seq_datapath #(
    .XLEN       (XLEN),
    .STRIDE_LOG2(STRIDE_LOG2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .trapCause (trapCause),
    .trapPc    (trapPc),
    .vecUpper  (vecBase[XLEN-1:1]),
    .wrMie     (statusWrMie),
    .wrMpie    (statusWrMpie),
    .wrMpp     (statusWrMpp),
    .privOut   (privLevel),
    .mieOut    (statusMie),
    .mpieOut   (statusMpie),
    .mppOut    (statusMpp),
    .causeOut  (causeReg),
    .epcOut    (epcReg),
    .redirectPc(redirectPc)
  );

  assign redirectValid = ctrl.redirect;

endmodule

// File: rtl/trap_seq_checker.sv
module trap_seq_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapValid,
  input logic [XLEN-1:0] trapCause,
  input logic [XLEN-1:0] trapPc,
  input logic            retValid,
  input logic            statusWrEn,
  input logic [1:0]      privLevel,
  input logic            statusMie,
  input logic            statusMpie,
  input logic [1:0]      statusMpp,
  input logic [XLEN-1:0] causeReg,
  input logic [XLEN-1:0] epcReg,
  input logic            redirectValid
);

  assert_priv_to_machine_R2: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (privLevel == 2'b11) && (statusMpp == $past(privLevel)));

  assert_mie_cleared_R3: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !statusMie);

  assert_mpie_set_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (statusMpie == ($past(statusMpie) || $past(statusMie))));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> (causeReg == $past(trapCause)) && (epcReg == $past(trapPc)));

  assert_return_priv_R7: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !trapValid) |=> (privLevel == $past(statusMpp)) && !statusMpie
                                 && $stable(statusMpp));

  assert_return_mie_R7: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !trapValid) |=> (statusMie == ($past(statusMie) || $past(statusMpie))));

  assert_redirect_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid == (trapValid || retValid));

  assert_load_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrEn && retValid && !trapValid) |=> !statusMpie);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!trapValid && !retValid && !statusWrEn) |=>
      $stable(privLevel) && $stable(statusMie) && $stable(statusMpie) &&
      $stable(statusMpp) && $stable(causeReg) && $stable(epcReg));

endmodule

bind trap_seq trap_seq_checker #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .trapValid    (trapValid),
  .trapCause    (trapCause),
  .trapPc       (trapPc),
  .retValid     (retValid),
  .statusWrEn   (statusWrEn),
  .privLevel    (privLevel),
  .statusMie    (statusMie),
  .statusMpie   (statusMpie),
  .statusMpp    (statusMpp),
  .causeReg     (causeReg),
  .epcReg       (epcReg),
  .redirectValid(redirectValid)
);

// File: tb/trap_seq_bench.sv
`timescale 1ns/1ps
module trap_seq_bench;

  localparam int XLEN = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            trapValid = 1'b0;
  logic [XLEN-1:0] trapCause = '0;
  logic [XLEN-1:0] trapPc = '0;
  logic            retValid = 1'b0;
  logic [XLEN-1:0] vecBase = '0;
  logic            statusWrEn = 1'b0;
  logic            statusWrMie = 1'b0;
  logic            statusWrMpie = 1'b0;
  logic [1:0]      statusWrMpp = 2'b00;
  logic [1:0]      privLevel;
  logic            statusMie;
  logic            statusMpie;
  logic [1:0]      statusMpp;
  logic [XLEN-1:0] causeReg;
  logic [XLEN-1:0] epcReg;
  logic            redirectValid;
  logic [XLEN-1:0] redirectPc;

  int testsRun = 0;
  int testsFailed = 0;

  logic [1:0]      mPriv, mMpp;
  logic            mMie, mMpie;
  logic [XLEN-1:0] mCause, mEpc;

  always #2.5 clk = ~clk;

  trap_seq #(.XLEN(XLEN)) u_trap_seq (
    .clk(clk), .rstN(rstN), .trapValid(trapValid), .trapCause(trapCause),
    .trapPc(trapPc), .retValid(retValid), .vecBase(vecBase),
    .statusWrEn(statusWrEn), .statusWrMie(statusWrMie),
    .statusWrMpie(statusWrMpie), .statusWrMpp(statusWrMpp),
    .privLevel(privLevel), .statusMie(statusMie), .statusMpie(statusMpie),
    .statusMpp(statusMpp), .causeReg(causeReg), .epcReg(epcReg),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] targetOf(input logic [XLEN-1:0] vb,
                                                input logic [XLEN-1:0] c);
    logic [XLEN-1:0] base;
    int unsigned code;
    base = vb & ~XLEN'(1);
    code = int'(c) % (1 << (XLEN-1));
    if (vb[0] && c[XLEN-1]) return XLEN'(int'(base) + 4 * code);
    return base;
  endfunction

  task automatic checkState(input string tag);
    check({tag, " priv"},  32'(privLevel),  32'(mPriv));
    check({tag, " mie"},   32'(statusMie),  32'(mMie));
    check({tag, " mpie"},  32'(statusMpie), 32'(mMpie));
    check({tag, " mpp"},   32'(statusMpp),  32'(mMpp));
    check({tag, " cause"}, 32'(causeReg),   32'(mCause));
    check({tag, " epc"},   32'(epcReg),     32'(mEpc));
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic step(input logic t, input logic r, input logic w,
                      input logic wMie, input logic wMpie, input logic [1:0] wMpp,
                      input logic [XLEN-1:0] c, input logic [XLEN-1:0] pc,
                      input logic [XLEN-1:0] vb);
    string tag;
    logic [XLEN-1:0] expPc;
    trapValid = t; retValid = r; statusWrEn = w;
    statusWrMie = wMie; statusWrMpie = wMpie; statusWrMpp = wMpp;
    trapCause = c; trapPc = pc; vecBase = vb;
    #1;
    check("R8 redirectValid", 32'(redirectValid), 32'(t | r));
    if (t) begin
      expPc = targetOf(vb, c);
      check((vb[0] && c[XLEN-1]) ? (t && r ? "R9 R6 target" : "R6 target")
                                 : (t && r ? "R9 R5 target" : "R5 target"),
            32'(redirectPc), 32'(expPc));
    end else if (r) begin
      check("R8 return target", 32'(redirectPc), 32'(mEpc));
    end
    if (t) begin
      tag = r ? "R9 trap wins" : (w ? "R10 load ignored on trap" : "R2 R3 R4 trap");
      mMpp = mPriv; mPriv = 2'b11;
      if (mMie) mMpie = 1'b1;
      mMie = 1'b0; mCause = c; mEpc = pc;
    end else if (r) begin
      tag = w ? "R10 load ignored on return" : "R7 return";
      mPriv = mMpp;
      if (mMpie) mMie = 1'b1;
      mMpie = 1'b0;
    end else if (w) begin
      tag = "R10 load";
      mMie = wMie; mMpie = wMpie; mMpp = (wMpp == 2'b00) ? 2'b00 : 2'b11;
    end else begin
      tag = "R11 hold";
    end
    @(posedge clk);
    @(negedge clk);
    trapValid = 1'b0; retValid = 1'b0; statusWrEn = 1'b0;
    checkState(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    mPriv = 2'b11; mMpp = 2'b00; mMie = 1'b0; mMpie = 1'b0; mCause = '0; mEpc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checkState("R1 reset");
    @(negedge clk);

    // Loads: all written saved-privilege values, legalized
    for (int v = 0; v < 4; v++)
      step(1'b0, 1'b0, 1'b1, v[0], v[1], 2'(v), '0, '0, '0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, '0, '0, '0);

    // State sweep over privilege, enable, saved enable, saved privilege and event kind
    for (int s = 0; s < 16; s++) begin
      for (int ev = 0; ev < 6; ev++) begin
        logic [1:0] p, mp;
        p  = s[0] ? 2'b11 : 2'b00;
        mp = s[3] ? 2'b11 : 2'b00;
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, p, '0, '0, '0);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, '0, '0, '0);
        step(1'b0, 1'b0, 1'b1, s[1], s[2], mp, '0, '0, '0);
        case (ev)
          0: step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'h85, XLEN'(8'h40 + s), 8'h21);
          1: step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, '0, '0, '0);
          2: step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 8'h03, XLEN'(8'h90 + s), 8'h31);
          3: step(1'b1, 1'b0, 1'b1, !s[1], !s[2], ~mp, 8'h81, 8'h12, 8'h10);
          4: step(1'b0, 1'b1, 1'b1, !s[1], 1'b1, ~mp, '0, '0, '0);
          default: step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 8'hff, 8'hff, 8'hff);
        endcase
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, '0, '0, '0);
      end
    end

    // Exhaustive target sweep over vector register and cause word
    for (int vb = 0; vb < 256; vb++)
      for (int c = 0; c < 256; c++)
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, XLEN'(c), XLEN'(vb ^ c), XLEN'(vb));

    // Return after a trap hands back the captured PC
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'h07, 8'hc4, 8'h01);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, '0, '0, '0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule